// File: doc/BRIEF.md
# Register-Read Pointer Controller

This block is the read side of a two-wire (I2C) target that serves a sensor controller's result registers. A bit-level bus engine, which sits outside the block, presents it with byte-level strobes: start (also used for a repeated start), an address byte, a write data byte, a request for one read byte, and stop. The block decodes the target address and keeps a register pointer. It returns one byte for each read request and moves the pointer by rules that depend on where it points.

Ten result registers form an ordered window that the pointer walks through and then sticks at the top of. One register number is the entry to a FIFO of fixed-size measurement blocks. The pointer never moves off that register, and each block is consumed whole as soon as reading of it begins. A streamlined read is a transaction that carries only the read address. When the streamlined option is enabled, such a read resumes at the remembered pointer. When it is disabled, such a read starts from register 0.

Top module: `rptr_read_ctrl`

## Requirements
- R1: The 7-bit target address is {DEV_HI, addr_sel}. Bit 0 of the address byte selects the direction, with 1 meaning read. A matching address byte raises addr_ack for the one following cycle. A transaction whose address does not match gets no acknowledge, and none of its read requests produces rd_valid.
- R2: rd_valid is low after reset. In a matched read transaction, each bus_rd_req raises rd_valid for exactly the following cycle, with the byte on rd_data.
- R3: Register numbers 0 to 9 are the result registers, in order X high, X low, Y high, Y low, Z1 high, Z1 low, Z2 high, Z2 low, AUX high, AUX low. Register i reads res_data[8i+7:8i]. The pointer advances by one after every byte served and takes no acknowledge into account.
- R4: The pointer never moves past register 9. Further bytes return register 9 again.
- R5: The first write byte after a matching write address sets the pointer. Later write bytes in the same transaction are ignored. A write, then a repeated start, then a read returns Reg(N) first.
- R6: With stream_en high, a read transaction that has no register write before it resumes at the current pointer. For example, after register 0 and register 1 have been read and the transaction has stopped, the next read starts at register 2.
- R7: With stream_en low, a read transaction starts from register 0 unless a register write has occurred since the last read transaction ended.
- R8: Register 10 (0x0A) is the FIFO port, and the pointer stays on it. Byte k of the head block is bits [8k+7:8k] of the pushed 32-bit block. Bytes 0 to 3 are served in order, and after byte 3 the block is removed.
- R9: If a transaction ends (start or stop) after at least one byte of a block has been served, that block is removed. The next FIFO byte is byte 0 of the following block.
- R10: A FIFO read while the FIFO is empty returns 0x00 and removes nothing. A block pushed afterwards is read from its byte 0.
- R11: A register number other than 0 to 10 reads 0x00, and the pointer stays where it is.
- R12: With stream_en high, a read-only transaction after FIFO reads continues at the FIFO register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 2 | Low two bits of the target address |
| stream_en | input | 1 | Enables streamlined resume |
| res_data | input | 8*NUM_RES | Result register bytes, register i at bits [8i+7:8i] |
| fifo_push | input | 1 | Pushes one measurement block |
| fifo_wblock | input | 8*BLK_BYTES | Block to push, byte k at bits [8k+7:8k] |
| bus_start | input | 1 | Start or repeated start seen |
| bus_stop | input | 1 | Stop seen |
| bus_addr_vld | input | 1 | bus_byte holds an address byte |
| bus_wr_vld | input | 1 | bus_byte holds a written data byte |
| bus_rd_req | input | 1 | Engine requests the next read byte |
| bus_byte | input | 8 | Address or write data byte |
| addr_ack | output | 1 | Registered address-match pulse |
| rd_valid | output | 1 | Registered read byte valid |
| rd_data | output | 8 | Registered read byte |

## Verification
The assertions assume that the bus engine raises at most one of its five strobes in any cycle. They also assume that it sends an address byte only right after a start, which is what lets the pointer, flag and phase updates be treated as mutually exclusive. The bench drives one strobe per task call, each held for exactly one cycle. Every transaction begins with bus_start. FIFO pushes are issued only between transactions, so a push never coincides with a read of the same block.

// File: rtl/rptr_pkg.sv
package rptr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_WREG, PH_WDAT, PH_READ, PH_SKIP
  } phase_e;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/rptr_txn.sv
module rptr_txn
  import rptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        dev_addr,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              bus_addr_vld,
  input  logic              bus_wr_vld,
  input  logic              bus_rd_req,
  input  logic [BYTE_W-1:0] bus_byte,
  output logic              addr_ack,
  output logic              reg_wr,
  output logic              rd_begin,
  output logic              serve,
  output logic              txn_end,
  output logic              rd_end
);
  phase_e phase, phase_nxt;
  logic   hit;

  assign hit      = bus_addr_vld && (phase == PH_ADDR) && (bus_byte[7:1] == dev_addr);
  assign txn_end  = bus_start | bus_stop;
  assign rd_end   = txn_end && (phase == PH_READ);
  assign reg_wr   = bus_wr_vld && (phase == PH_WREG);
  assign rd_begin = hit && bus_byte[0];
  assign serve    = bus_rd_req && (phase == PH_READ);

  always_comb begin
    phase_nxt = phase;
    if (bus_start)                               phase_nxt = PH_ADDR;
    else if (bus_stop)                           phase_nxt = PH_IDLE;
    else if (bus_addr_vld && phase == PH_ADDR)   phase_nxt = !hit ? PH_SKIP :
                                                             (bus_byte[0] ? PH_READ : PH_WREG);
    else if (reg_wr)                             phase_nxt = PH_WDAT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      addr_ack <= 1'b0;
    end else begin
      phase    <= phase_nxt;
      addr_ack <= hit;
    end
  end

  // R1: input contract, one strobe per cycle
  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_start, bus_stop, bus_addr_vld, bus_wr_vld, bus_rd_req}));
  // R1: an acknowledge always follows an address byte
  assert_ack_after_addr_R1: assert property (@(posedge clk) disable iff (rst)
    addr_ack |-> $past(bus_addr_vld));
endmodule

// File: rtl/rptr_blk_fifo.sv
module rptr_blk_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             full, do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_C);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST_A) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST_A) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R10: the controller never asks to drop a block that is not there
  assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/rptr_read_ctrl.sv
module rptr_read_ctrl
  import rptr_pkg::*;
#(
  parameter logic [4:0] DEV_HI     = 5'b10010,
  parameter int         NUM_RES    = 10,
  parameter int         BLK_BYTES  = 4,
  parameter int         FIFO_DEPTH = 4,
  parameter logic [7:0] FIFO_REG   = 8'h0A
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              addr_sel,
  input  logic                    stream_en,
  input  logic [8*NUM_RES-1:0]    res_data,
  input  logic                    fifo_push,
  input  logic [8*BLK_BYTES-1:0]  fifo_wblock,
  input  logic                    bus_start,
  input  logic                    bus_stop,
  input  logic                    bus_addr_vld,
  input  logic                    bus_wr_vld,
  input  logic                    bus_rd_req,
  input  logic [7:0]              bus_byte,
  output logic                    addr_ack,
  output logic                    rd_valid,
  output logic [7:0]              rd_data
);
  localparam int BLK_W  = BYTE_W * BLK_BYTES;
  localparam int RIDX_W = (NUM_RES > 1) ? $clog2(NUM_RES) : 1;
  localparam int BOFF_W = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;
  localparam logic [7:0]        LAST_REG = 8'(NUM_RES - 1);
  localparam logic [BOFF_W-1:0] LAST_OFF = BOFF_W'(BLK_BYTES - 1);

  logic reg_wr, rd_begin, serve, txn_end, rd_end;
  logic [7:0]        ptr;
  logic              ptr_set;
  logic [BOFF_W-1:0] boff;
  logic [BLK_W-1:0]  head;
  logic              fifo_empty, fifo_take, fifo_pop;
  logic              is_res, is_fifo;
  logic [7:0]        srv_byte;
  logic [7:0]        res_arr [NUM_RES];
  logic [7:0]        blk_arr [BLK_BYTES];

  rptr_txn txn_i (
    .clk, .rst,
    .dev_addr ({DEV_HI, addr_sel}),
    .bus_start, .bus_stop, .bus_addr_vld, .bus_wr_vld, .bus_rd_req, .bus_byte,
    .addr_ack, .reg_wr, .rd_begin, .serve, .txn_end, .rd_end
  );

  rptr_blk_fifo #(.WIDTH(BLK_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk, .rst,
    .push  (fifo_push),
    .wdata (fifo_wblock),
    .pop   (fifo_pop),
    .head  (head),
    .empty (fifo_empty)
  );

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    assign res_arr[g] = res_data[8*g +: 8];
  end
  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_blk
    assign blk_arr[g] = head[8*g +: 8];
  end

  assign is_res    = (ptr <= LAST_REG);
  assign is_fifo   = (ptr == FIFO_REG);
  assign fifo_take = serve && is_fifo && !fifo_empty;
  assign fifo_pop  = (fifo_take && boff == LAST_OFF) || (txn_end && boff != '0);

  always_comb begin
    if (is_res)                       srv_byte = res_arr[ptr[RIDX_W-1:0]];
    else if (is_fifo && !fifo_empty)  srv_byte = blk_arr[boff];
    else                              srv_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= 8'h00;
      ptr_set  <= 1'b0;
      boff     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= 1'b0;
      if (rd_end) ptr_set <= 1'b0;
      if (reg_wr) begin
        ptr     <= bus_byte;
        ptr_set <= 1'b1;
      end
      if (rd_begin && !stream_en && !ptr_set) ptr <= 8'h00;
      if (serve) begin
        rd_valid <= 1'b1;
        rd_data  <= srv_byte;
        if (is_res && ptr != LAST_REG) ptr <= ptr + 8'd1;
      end
      if (fifo_pop)       boff <= '0;
      else if (fifo_take) boff <= boff + 1'b1;
    end
  end

  // R2: every served request yields exactly one valid byte next cycle
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    serve |=> rd_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !serve |=> !rd_valid);
  // R4: pointer sticks at the last result register
  assert_saturate_R4: assert property (@(posedge clk) disable iff (rst)
    (serve && ptr == LAST_REG) |=> ptr == LAST_REG);
  // R8: pointer stays on the FIFO register while bytes are served
  assert_fifo_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (serve && ptr == FIFO_REG) |=> ptr == FIFO_REG);
  // R9: an open block always has data behind it
  assert_open_block_R9: assert property (@(posedge clk) disable iff (rst)
    (boff != '0) |-> !fifo_empty);
endmodule

// File: tb/rptr_read_ctrl_tb.sv
module rptr_read_ctrl_tb_top;
  localparam int NRES = 10;
  localparam logic [7:0] WADR = 8'h92;  // {5'b10010, 2'b01, 0}
  localparam logic [7:0] RADR = 8'h93;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] addr_sel = 2'b01;
  logic stream_en = 1'b1;
  logic [8*NRES-1:0] res_data;
  logic fifo_push = 1'b0;
  logic [31:0] fifo_wblock = '0;
  logic bus_start = 0, bus_stop = 0, bus_addr_vld = 0, bus_wr_vld = 0, bus_rd_req = 0;
  logic [7:0] bus_byte = '0;
  logic addr_ack, rd_valid;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  string cur_req = "R2";

  always #2.5 clk = ~clk;

  rptr_read_ctrl dut_i (
    .clk, .rst, .addr_sel, .stream_en, .res_data, .fifo_push, .fifo_wblock,
    .bus_start, .bus_stop, .bus_addr_vld, .bus_wr_vld, .bus_rd_req, .bus_byte,
    .addr_ack, .rd_valid, .rd_data
  );

  initial for (int i = 0; i < NRES; i++) res_data[8*i +: 8] = 8'h10 + 8'(i);

  // behavioural reference model
  int m_ptr, m_phase, m_boff;
  bit m_set;
  logic [31:0] m_q[$];
  logic exp_valid, exp_ack;
  logic [7:0] exp_data;

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0; m_phase = 0; m_boff = 0; m_set = 0; m_q.delete();
      exp_valid = 0; exp_ack = 0; exp_data = 0;
    end else begin
      bit was_full;
      was_full = (m_q.size() == 4);
      exp_valid = 0; exp_ack = 0;
      if (bus_start || bus_stop) begin
        if (m_boff != 0) begin void'(m_q.pop_front()); m_boff = 0; end
        if (m_phase == 4) m_set = 0;
        m_phase = bus_start ? 1 : 0;
      end else if (bus_addr_vld && m_phase == 1) begin
        if (bus_byte[7:1] == {5'b10010, addr_sel}) begin
          exp_ack = 1;
          if (bus_byte[0]) begin
            m_phase = 4;
            if (!stream_en && !m_set) m_ptr = 0;
          end else m_phase = 2;
        end else m_phase = 5;
      end else if (bus_wr_vld && m_phase == 2) begin
        m_ptr = bus_byte; m_set = 1; m_phase = 3;
      end else if (bus_rd_req && m_phase == 4) begin
        exp_valid = 1;
        if (m_ptr < NRES) begin
          exp_data = res_data[8*m_ptr +: 8];
          if (m_ptr < NRES - 1) m_ptr++;
        end else if (m_ptr == 10 && m_q.size() > 0) begin
          exp_data = m_q[0][8*m_boff +: 8];
          m_boff++;
          if (m_boff == 4) begin void'(m_q.pop_front()); m_boff = 0; end
        end else exp_data = 8'h00;
      end
      if (fifo_push && !was_full) m_q.push_back(fifo_wblock);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (rd_valid !== exp_valid || addr_ack !== exp_ack ||
          (exp_valid && rd_data !== exp_data)) begin
        bad++;
        $display("FAIL %s cycle compare: valid=%0b ack=%0b data=%h expected valid=%0b ack=%0b data=%h",
                 cur_req, rd_valid, addr_ack, rd_data, exp_valid, exp_ack, exp_data);
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input int kind, input logic [7:0] b);
    @(posedge clk); #1;
    bus_byte = b;
    case (kind)
      0: bus_start = 1;
      1: bus_stop = 1;
      2: bus_addr_vld = 1;
      3: bus_wr_vld = 1;
      default: bus_rd_req = 1;
    endcase
    @(posedge clk); #1;
    {bus_start, bus_stop, bus_addr_vld, bus_wr_vld, bus_rd_req} = '0;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    pulse(4, 8'h00);
    chk({7'd0, rd_valid}, 8'h01, tag);
    chk(rd_data, exp, tag);
  endtask

  task automatic push(input logic [31:0] blk);
    @(posedge clk); #1; fifo_push = 1; fifo_wblock = blk;
    @(posedge clk); #1; fifo_push = 0;
  endtask

  task automatic begin_read();  pulse(0, 0); pulse(2, RADR); endtask
  task automatic full_read(input logic [7:0] n);
    pulse(0, 0); pulse(2, WADR); pulse(3, n); pulse(0, 0); pulse(2, RADR);
  endtask
  task automatic stop(); pulse(1, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R2";
    chk({6'd0, rd_valid, addr_ack}, 8'h00, "R2 reset outputs");
    chk(rd_data, 8'h00, "R2 reset data");
    rst = 0;

    cur_req = "R6";
    pulse(0, 0); pulse(2, RADR);
    chk({7'd0, addr_ack}, 8'h01, "R1 ack on match");
    rd(8'h10, "R3 first result reg");
    rd(8'h11, "R3 increment");
    stop();
    begin_read(); rd(8'h12, "R6 streamlined resume"); stop();

    cur_req = "R4";
    full_read(8'd7);
    rd(8'h17, "R5 full read Reg(N)");
    rd(8'h18, "R3 next");
    rd(8'h19, "R4 last");
    rd(8'h19, "R4 saturate");
    rd(8'h19, "R4 saturate again");
    stop();

    cur_req = "R1";
    pulse(0, 0); pulse(2, 8'h95);
    chk({7'd0, addr_ack}, 8'h00, "R1 no ack on mismatch");
    pulse(4, 0);
    chk({7'd0, rd_valid}, 8'h00, "R1 no data on mismatch");
    stop();

    cur_req = "R7";
    stream_en = 0;
    begin_read(); rd(8'h10, "R7 restart at 0"); stop();
    full_read(8'd3); rd(8'h13, "R5 full read N=3"); stop();
    pulse(0, 0); pulse(2, WADR); pulse(3, 8'd5); pulse(3, 8'd8); stop();
    begin_read(); rd(8'h15, "R5 write sets pointer, extra byte ignored"); stop();
    begin_read(); rd(8'h10, "R7 flag cleared after read"); stop();

    cur_req = "R11";
    stream_en = 1;
    full_read(8'h20); rd(8'h00, "R11 unmapped"); rd(8'h00, "R11 unmapped hold"); stop();
    begin_read(); rd(8'h00, "R11 pointer held"); stop();

    cur_req = "R10";
    full_read(8'h0A); rd(8'h00, "R10 empty FIFO"); stop();
    push(32'hA3A2A1A0); push(32'hB3B2B1B0); push(32'hC3C2C1C0);
    cur_req = "R8";
    begin_read();
    rd(8'hA0, "R12 resume at FIFO");
    rd(8'hA1, "R8 byte 1"); rd(8'hA2, "R8 byte 2"); rd(8'hA3, "R8 byte 3");
    rd(8'hB0, "R8 next block");
    cur_req = "R9";
    stop();
    begin_read(); rd(8'hC0, "R9 partial block dropped"); stop();
    cur_req = "R10";
    begin_read(); rd(8'h00, "R10 empty after drain"); rd(8'h00, "R10 empty again"); stop();
    push(32'hD3D2D1D0);
    begin_read(); rd(8'hD0, "R10 no pop on empty read"); rd(8'hD1, "R8 order"); stop();

    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule